// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Build-Time Write Policy

This block is a direct-mapped data cache. It sits between a processor load/store port and a slower lower-level memory. Each address maps to exactly one line. A single tag comparison, qualified by that line's valid bit, decides between a hit and a miss, so the block holds no replacement state. A read hit returns its word one cycle after the request is accepted. A miss stalls the processor while a whole line moves over the memory port, one word per handshake.

Two build-time parameters select the write behaviour. `WRITE_BACK` chooses what a write hit does. With write-through, the word goes into the cache and also straight to memory. With write-back, the word goes into the cache only and the line is marked dirty. `WRITE_ALLOC` chooses what a write miss does. With allocation, the line is fetched first and the write is then handled as a hit. Without allocation, the word goes to memory only and the cache is left untouched. In write-back mode, a miss that lands on a dirty line first copies the old line out to memory, then refills.

The memory port is a simple request/acknowledge interface. `memReq` is held until `memAck`, and read data arrives with the acknowledge. The default configuration has 16 lines of eight 32-bit words.

Top module: `dm_cache`

## Requirements
- R1: The line index is the `INDEX_W` address bits directly above the in-line offset (bits 8..5 by default, with bits 4..2 selecting the word and 1..0 the byte). The bits above the index (31..9) are the tag. Two addresses with equal index and different tag displace each other.
- R2: A read hit keeps `cpuStall` low and raises `cpuRvalid` with the latest written data in the cycle right after the accepting clock edge. It causes no memory traffic.
- R3: A read miss raises `cpuStall` and fetches the whole line as `WORDS_PER_LINE` memory reads. It then returns the requested word on `cpuRvalid`, in a cycle where `cpuStall` is already low.
- R4: With `WRITE_BACK`=0, a write hit updates the cached word and also issues exactly one memory write of that word with the same byte enables.
- R5: With `WRITE_BACK`=1, a write hit updates only the cached word and marks the line dirty. No memory traffic results.
- R6: With `WRITE_ALLOC`=1, a write miss fetches the line first and then applies the write-hit action of the selected hit policy.
- R7: With `WRITE_ALLOC`=0, a write miss issues one memory write of the word and changes no line. A later read of that address is still a miss.
- R8: With `WRITE_BACK`=1, a miss whose line is valid and dirty first writes all `WORDS_PER_LINE` old words to the old tag's addresses. Only after that do any refill reads start.
- R9: A refilled line is clean. A miss that replaces a clean or invalid line writes nothing back.
- R10: A write changes only the bytes whose `cpuBe` bit is set (bit n covers data bits 8n+7..8n). The other bytes of the word keep their values.
- R11: After reset, `cpuStall`, `cpuRvalid` and `memReq` are low and no line is valid, so the first access of any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Access request; accepted on an edge where `cpuStall` is low |
| cpuWe | input | 1 | 1 for write, 0 for read |
| cpuAddr | input | ADDR_W | Byte address of the access |
| cpuWdata | input | WORD_W | Write data |
| cpuBe | input | WORD_W/8 | Byte enables for writes |
| cpuStall | output | 1 | High while the cache is busy and cannot accept a request |
| cpuRdata | output | WORD_W | Read result |
| cpuRvalid | output | 1 | One-cycle pulse marking `cpuRdata` valid |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | WORD_W | Memory write data |
| memBe | output | WORD_W/8 | Memory write byte enables |
| memAck | input | 1 | Memory completes the current word |
| memRdata | input | WORD_W | Memory read data, valid with `memAck` |

## Verification
A read hit must produce `cpuRvalid` exactly one cycle after its accepting edge. The bench records the cycle count when it drives each request, and the scoreboard monitor compares against that number at the falling edge where the pulse appears. A miss result has no fixed arrival cycle. It is instead required to come later than the hit slot, and the driver waits for `cpuStall` to drop, plus one more cycle, before it checks that the queue has drained. Memory traffic belonging to each access is checked in that same settled cycle: read beats, write beats, and which kind of operation came first are compared with counts that a reference tag model predicts. Two instances run in lockstep, one write-back with allocation and one write-through without allocation.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_FINISH,
    ST_WORD
  } ctlState_e;

  typedef enum logic [1:0] {
    SEL_EVICT,
    SEL_FILL,
    SEL_WORD
  } memSel_e;

  typedef struct packed {
    logic    acceptReq;
    logic    usePending;
    logic    cpuWrite;
    logic    fillWrite;
    logic    installLine;
    logic    loadRdata;
    memSel_e memSel;
  } ctlStrobes_t;

endpackage

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1,
  localparam int BEAT_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              hit,
  input  logic              victimDirty,
  input  logic              memAck,
  output ctlStrobes_t       ctl,
  output logic [BEAT_W-1:0] beat,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe
);

  localparam logic IS_WB    = (WRITE_BACK != 0);
  localparam logic IS_ALLOC = (WRITE_ALLOC != 0);

  ctlState_e state, nextState;
  logic      pendWe;
  logic      beatClr, beatInc, lastBeat;

  assign lastBeat = (beat == BEAT_W'(WORDS - 1));

  always_comb begin
    ctl       = '0;
    ctl.memSel = SEL_FILL;
    nextState = state;
    beatClr   = 1'b0;
    beatInc   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          ctl.acceptReq = 1'b1;
          beatClr       = 1'b1;
          if (hit) begin
            if (cpuWe) begin
              ctl.cpuWrite = 1'b1;
              if (!IS_WB) nextState = ST_WORD;
            end else begin
              ctl.loadRdata = 1'b1;
            end
          end else if (cpuWe && !IS_ALLOC) begin
            nextState = ST_WORD;
          end else if (IS_WB && victimDirty) begin
            nextState = ST_EVICT;
          end else begin
            nextState = ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        ctl.usePending = 1'b1;
        ctl.memSel     = SEL_EVICT;
        if (memAck) begin
          if (lastBeat) begin
            beatClr   = 1'b1;
            nextState = ST_FILL;
          end else begin
            beatInc = 1'b1;
          end
        end
      end
      ST_FILL: begin
        ctl.usePending = 1'b1;
        ctl.memSel     = SEL_FILL;
        if (memAck) begin
          ctl.fillWrite = 1'b1;
          if (lastBeat) begin
            ctl.installLine = 1'b1;
            beatClr         = 1'b1;
            nextState       = ST_FINISH;
          end else begin
            beatInc = 1'b1;
          end
        end
      end
      ST_FINISH: begin
        ctl.usePending = 1'b1;
        if (pendWe) begin
          ctl.cpuWrite = 1'b1;
          nextState    = IS_WB ? ST_IDLE : ST_WORD;
        end else begin
          ctl.loadRdata = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_WORD: begin
        ctl.usePending = 1'b1;
        ctl.memSel     = SEL_WORD;
        if (memAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      beat   <= '0;
      pendWe <= 1'b0;
    end else begin
      state <= nextState;
      if (beatClr)      beat <= '0;
      else if (beatInc) beat <= beat + 1'b1;
      if (ctl.acceptReq) pendWe <= cpuWe;
    end
  end

  assign cpuStall = (state != ST_IDLE);
  assign memReq   = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WORD);
  assign memWe    = (state == ST_EVICT) || (state == ST_WORD);

  // R2
  hit_read_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && !cpuWe && hit) |=> !cpuStall);

  // R7
  noalloc_direct_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && cpuWe && !hit && !IS_ALLOC) |=> (memReq && memWe));

  // R8
  dirty_evict_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && !hit && victimDirty && IS_WB && !(cpuWe && !IS_ALLOC))
      |=> (memReq && memWe));

endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int WORDS      = 8,
  parameter int INDEX_W    = 4,
  parameter int WRITE_BACK = 1,
  localparam int BYTES     = WORD_W / 8,
  localparam int BYTE_OFF  = $clog2(BYTES),
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int LINES     = 1 << INDEX_W,
  localparam int TAG_W     = ADDR_W - INDEX_W - WSEL_W - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [WSEL_W-1:0] beat,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [BYTES-1:0]  cpuBe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe
);

  localparam int WA_W = ADDR_W - BYTE_OFF;

  logic [WA_W-1:0]   pendWa;
  logic [WORD_W-1:0] pendWdata;
  logic [BYTES-1:0]  pendBe;

  logic [LINES-1:0]  validArr, dirtyArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [WORD_W-1:0] dataArr [LINES][WORDS];

  logic [WA_W-1:0]    lkWa;
  logic [INDEX_W-1:0] lkIdx, pIdx;
  logic [TAG_W-1:0]   lkTag, pTag, victimTag;
  logic [WSEL_W-1:0]  lkWord;
  logic [WORD_W-1:0]  curWord, wdSel, mergedWord;
  logic [BYTES-1:0]   beSel;
  logic               unusedLowBits;

  assign unusedLowBits = ^cpuAddr[BYTE_OFF-1:0];

  assign lkWa   = ctl.usePending ? pendWa : cpuAddr[ADDR_W-1:BYTE_OFF];
  assign lkWord = lkWa[WSEL_W-1:0];
  assign lkIdx  = lkWa[WSEL_W +: INDEX_W];
  assign lkTag  = lkWa[WA_W-1 -: TAG_W];
  assign pIdx   = pendWa[WSEL_W +: INDEX_W];
  assign pTag   = pendWa[WA_W-1 -: TAG_W];
  assign victimTag = tagArr[pIdx];

  assign hit         = validArr[lkIdx] && (tagArr[lkIdx] == lkTag);
  assign victimDirty = validArr[lkIdx] && dirtyArr[lkIdx];

  assign curWord = dataArr[lkIdx][lkWord];
  assign wdSel   = ctl.usePending ? pendWdata : cpuWdata;
  assign beSel   = ctl.usePending ? pendBe : cpuBe;

  for (genvar b = 0; b < BYTES; b++) begin : gLane
    assign mergedWord[b*8 +: 8] = beSel[b] ? wdSel[b*8 +: 8] : curWord[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (ctl.acceptReq) begin
      pendWa    <= cpuAddr[ADDR_W-1:BYTE_OFF];
      pendWdata <= cpuWdata;
      pendBe    <= cpuBe;
    end
    if (ctl.cpuWrite)    dataArr[lkIdx][lkWord] <= mergedWord;
    if (ctl.fillWrite)   dataArr[pIdx][beat]    <= memRdata;
    if (ctl.installLine) tagArr[pIdx]           <= pTag;
    if (ctl.loadRdata)   cpuRdata               <= curWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validArr  <= '0;
      dirtyArr  <= '0;
      cpuRvalid <= 1'b0;
    end else begin
      cpuRvalid <= ctl.loadRdata;
      if (ctl.installLine) begin
        validArr[pIdx] <= 1'b1;
        dirtyArr[pIdx] <= 1'b0;
      end
      if (ctl.cpuWrite && (WRITE_BACK != 0)) dirtyArr[lkIdx] <= 1'b1;
    end
  end

  always_comb begin
    case (ctl.memSel)
      SEL_EVICT: begin
        memAddr  = {victimTag, pIdx, beat, {BYTE_OFF{1'b0}}};
        memWdata = dataArr[pIdx][beat];
        memBe    = '1;
      end
      SEL_WORD: begin
        memAddr  = {pendWa, {BYTE_OFF{1'b0}}};
        memWdata = pendWdata;
        memBe    = pendBe;
      end
      default: begin
        memAddr  = {pTag, pIdx, beat, {BYTE_OFF{1'b0}}};
        memWdata = dataArr[pIdx][beat];
        memBe    = '1;
      end
    endcase
  end

  // R9
  installed_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.installLine |=> (validArr[pIdx] && !dirtyArr[pIdx]));

  // R8
  evict_old_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.memSel == SEL_EVICT) |-> (victimTag != pTag));

endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_LINE = 8,
  parameter int INDEX_W        = 4,
  parameter int WRITE_BACK     = 1,
  parameter int WRITE_ALLOC    = 1,
  localparam int BYTES         = WORD_W / 8,
  localparam int BEAT_W        = $clog2(WORDS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [BYTES-1:0]  cpuBe,
  output logic              cpuStall,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              cpuRvalid,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRdata
);

  ctlStrobes_t       ctl;
  logic [BEAT_W-1:0] beat;
  logic              hit, victimDirty;

  dmc_control #(
    .WORDS       (WORDS_PER_LINE),
    .WRITE_BACK  (WRITE_BACK),
    .WRITE_ALLOC (WRITE_ALLOC)
  ) uCtl (
    .clk         (clk),
    .rst         (rst),
    .cpuReq      (cpuReq),
    .cpuWe       (cpuWe),
    .hit         (hit),
    .victimDirty (victimDirty),
    .memAck      (memAck),
    .ctl         (ctl),
    .beat        (beat),
    .cpuStall    (cpuStall),
    .memReq      (memReq),
    .memWe       (memWe)
  );

  dmc_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .WORDS      (WORDS_PER_LINE),
    .INDEX_W    (INDEX_W),
    .WRITE_BACK (WRITE_BACK)
  ) uDp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .beat        (beat),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .cpuBe       (cpuBe),
    .memRdata    (memRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .cpuRdata    (cpuRdata),
    .cpuRvalid   (cpuRvalid),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memBe       (memBe)
  );

endmodule

// File: tb/tb_dm_cache.sv
`timescale 1ns/1ps

module tb_lowmem (
  input  logic        clk,
  input  logic        rst,
  input  logic        memReq,
  input  logic        memWe,
  input  logic [31:0] memAddr,
  input  logic [31:0] memWdata,
  input  logic [3:0]  memBe,
  output logic        memAck,
  output logic [31:0] memRdata
);
  logic [31:0] store [int unsigned];
  int rdBeats = 0;
  int wrBeats = 0;
  int opCount = 0;
  bit firstWe = 0;

  function automatic logic [31:0] initWord(int unsigned wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] peek(int unsigned wa);
    if (store.exists(wa)) return store[wa];
    return initWord(wa);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      memAck <= 1'b0;
    end else if (memReq && !memAck) begin
      int unsigned wa;
      logic [31:0] w;
      wa = memAddr >> 2;
      memAck <= 1'b1;
      if (opCount == 0) firstWe = memWe;
      opCount++;
      if (memWe) begin
        w = peek(wa);
        for (int b = 0; b < 4; b++) if (memBe[b]) w[b*8 +: 8] = memWdata[b*8 +: 8];
        store[wa] = w;
        wrBeats++;
      end else begin
        memRdata <= peek(wa);
        rdBeats++;
      end
    end else begin
      memAck <= 1'b0;
    end
  end
endmodule

module tb_dm_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0]  cpuBe = '0;

  logic        stall   [2];
  logic        rvalid  [2];
  logic [31:0] rdata   [2];
  logic        mReq    [2];
  logic        mWe     [2];
  logic [31:0] mAddr   [2];
  logic [31:0] mWdata  [2];
  logic [3:0]  mBe     [2];
  logic        mAck    [2];
  logic [31:0] mRdata  [2];

  // instance 0: write-back + allocate, instance 1: write-through + no allocate
  dm_cache #(.WRITE_BACK(1), .WRITE_ALLOC(1)) dut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuStall(stall[0]), .cpuRdata(rdata[0]),
    .cpuRvalid(rvalid[0]), .memReq(mReq[0]), .memWe(mWe[0]), .memAddr(mAddr[0]),
    .memWdata(mWdata[0]), .memBe(mBe[0]), .memAck(mAck[0]), .memRdata(mRdata[0]));

  dm_cache #(.WRITE_BACK(0), .WRITE_ALLOC(0)) dutWt (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuStall(stall[1]), .cpuRdata(rdata[1]),
    .cpuRvalid(rvalid[1]), .memReq(mReq[1]), .memWe(mWe[1]), .memAddr(mAddr[1]),
    .memWdata(mWdata[1]), .memBe(mBe[1]), .memAck(mAck[1]), .memRdata(mRdata[1]));

  tb_lowmem mem0 (.clk(clk), .rst(rst), .memReq(mReq[0]), .memWe(mWe[0]), .memAddr(mAddr[0]),
    .memWdata(mWdata[0]), .memBe(mBe[0]), .memAck(mAck[0]), .memRdata(mRdata[0]));
  tb_lowmem mem1 (.clk(clk), .rst(rst), .memReq(mReq[1]), .memWe(mWe[1]), .memAddr(mAddr[1]),
    .memWdata(mWdata[1]), .memBe(mBe[1]), .memAck(mAck[1]), .memRdata(mRdata[1]));

  int nChecks = 0;
  int nFails  = 0;
  int cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycleCnt);
    end
  endtask

  // scoreboard items
  typedef struct {
    logic [31:0] data;
    bit          hit;
    int          issue;
  } exp_t;
  exp_t  expQ0[$], expQ1[$];
  string noteQ0[$], noteQ1[$];

  // reference tag model and coherent data view
  bit          refValid [2][16];
  bit          refDirty [2][16];
  int unsigned refTag   [2][16];
  logic [31:0] shadow [int unsigned];

  function automatic logic [31:0] shadowRead(int unsigned wa);
    if (shadow.exists(wa)) return shadow[wa];
    return mem0.initWord(wa);
  endfunction

  task automatic popCheck(int k);
    exp_t  e;
    string n;
    if (k == 0) begin
      if (expQ0.size() == 0) begin check(0, "R2 unexpected rvalid", rdata[0], 32'h0); return; end
      e = expQ0.pop_front(); n = noteQ0.pop_front();
    end else begin
      if (expQ1.size() == 0) begin check(0, "R2 unexpected rvalid", rdata[1], 32'h0); return; end
      e = expQ1.pop_front(); n = noteQ1.pop_front();
    end
    check(rdata[k] == e.data, $sformatf("%s read data inst%0d", n, k), rdata[k], e.data);
    if (e.hit)
      check(cycleCnt == e.issue + 1, $sformatf("R2 hit latency inst%0d", k),
            cycleCnt - e.issue, 32'd1);
    else
      check(cycleCnt > e.issue + 1, $sformatf("R3 miss must stall inst%0d", k),
            cycleCnt - e.issue, 32'd2);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rvalid[0]) popCheck(0);
      if (rvalid[1]) popCheck(1);
    end
  end

  task automatic doAccess(bit we, logic [31:0] addr, logic [31:0] wd, logic [3:0] be, string note);
    int unsigned wa, idx, tg;
    bit    h[2];
    int    rdE[2], wrE[2];
    bit    ev[2];
    int    rd0[2], wr0[2];
    bit    stallAfter[2];
    string lbl[2];
    logic [31:0] w;
    exp_t e;
    wa  = addr >> 2;
    idx = addr[8:5];
    tg  = addr[31:9];
    for (int k = 0; k < 2; k++) begin
      bit wb, alloc, dirtyVic;
      wb = (k == 0); alloc = (k == 0);
      h[k] = refValid[k][idx] && refTag[k][idx] == tg;
      dirtyVic = wb && refValid[k][idx] && refDirty[k][idx];
      rdE[k] = 0; wrE[k] = 0; ev[k] = 0;
      if (!we) begin
        if (!h[k]) begin
          if (dirtyVic) begin wrE[k] = 8; ev[k] = 1; end
          rdE[k] = 8;
          refValid[k][idx] = 1; refTag[k][idx] = tg; refDirty[k][idx] = 0;
        end
        lbl[k] = h[k] ? "R2" : (ev[k] ? "R8" : "R3");
      end else if (h[k]) begin
        if (wb) refDirty[k][idx] = 1; else wrE[k] = 1;
        lbl[k] = wb ? "R5" : "R4";
      end else if (alloc) begin
        if (dirtyVic) begin wrE[k] = 8; ev[k] = 1; end
        rdE[k] = 8;
        refValid[k][idx] = 1; refTag[k][idx] = tg; refDirty[k][idx] = 0;
        if (wb) refDirty[k][idx] = 1; else wrE[k] += 1;
        lbl[k] = "R6";
      end else begin
        wrE[k] = 1;
        lbl[k] = "R7";
      end
    end
    if (we) begin
      w = shadowRead(wa);
      for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = wd[b*8 +: 8];
      shadow[wa] = w;
    end

    @(negedge clk);
    while (stall[0] || stall[1]) @(negedge clk);
    mem0.opCount = 0; mem1.opCount = 0;
    rd0[0] = mem0.rdBeats; wr0[0] = mem0.wrBeats;
    rd0[1] = mem1.rdBeats; wr0[1] = mem1.wrBeats;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd; cpuBe = be;
    if (!we) begin
      e.data = shadowRead(wa); e.issue = cycleCnt;
      e.hit = h[0]; expQ0.push_back(e); noteQ0.push_back(note);
      e.hit = h[1]; expQ1.push_back(e); noteQ1.push_back(note);
    end
    @(negedge clk);
    stallAfter[0] = stall[0]; stallAfter[1] = stall[1];
    cpuReq = 1'b0;
    while (stall[0] || stall[1]) @(negedge clk);
    @(negedge clk);

    for (int k = 0; k < 2; k++) begin
      int dr, dw;
      bit fw;
      dr = (k == 0) ? mem0.rdBeats - rd0[0] : mem1.rdBeats - rd0[1];
      dw = (k == 0) ? mem0.wrBeats - wr0[0] : mem1.wrBeats - wr0[1];
      fw = (k == 0) ? mem0.firstWe : mem1.firstWe;
      check(dr == rdE[k], $sformatf("%s/%s read beats inst%0d", lbl[k], note, k), dr, rdE[k]);
      check(dw == wrE[k], $sformatf("%s/%s write beats inst%0d", lbl[k], note, k), dw, wrE[k]);
      if (ev[k]) check(fw == 1'b1, $sformatf("R8 writeback before refill inst%0d", k), fw, 1);
      if (!we && h[k]) check(stallAfter[k] == 1'b0, $sformatf("R2 no stall on hit inst%0d", k),
                             stallAfter[k], 0);
      if (k == 1 && we)
        check(mem1.peek(wa) == shadow[wa], $sformatf("%s/%s lower memory word", lbl[k], note),
              mem1.peek(wa), shadow[wa]);
    end
    check(expQ0.size() == 0 && expQ1.size() == 0, $sformatf("R3/%s result delivered", note),
          expQ0.size() + expQ1.size(), 0);
  endtask

  task automatic finalFlushCheck();
    foreach (shadow[wa]) begin
      int unsigned idx, tg;
      idx = (wa >> 3) & 15;
      tg  = wa >> 7;
      check(mem1.peek(wa) == shadow[wa], "R4 write-through memory coherent", mem1.peek(wa), shadow[wa]);
      if (!(refValid[0][idx] && refTag[0][idx] == tg && refDirty[0][idx]))
        check(mem0.peek(wa) == shadow[wa], "R8 evicted data reached memory", mem0.peek(wa), shadow[wa]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  localparam logic [31:0] A = 32'h0000_0100;          // index 8, tag 0
  localparam logic [31:0] B = 32'h0000_0300;          // index 8, tag 1
  localparam logic [31:0] C = 32'h0000_1060;          // index 3, tag 8
  localparam logic [31:0] D = 32'h0000_21E4;          // index 15, tag 16

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    for (int k = 0; k < 2; k++) begin
      check(stall[k] == 0, "R11 stall low after reset", stall[k], 0);
      check(rvalid[k] == 0, "R11 rvalid low after reset", rvalid[k], 0);
      check(mReq[k] == 0, "R11 memReq low after reset", mReq[k], 0);
    end
    doAccess(0, A, 0, 0, "R11");            // first access misses everywhere
    doAccess(0, A, 0, 0, "R2");
    doAccess(0, A + 4, 0, 0, "R2");
    doAccess(1, A + 8, 32'hCAFE_BEEF, 4'b0011, "R10");
    doAccess(0, A + 8, 0, 0, "R10");
    doAccess(0, B, 0, 0, "R1");             // conflict: evicts dirty A in write-back
    doAccess(0, A, 0, 0, "R9");             // victim B is clean: no writeback
    doAccess(1, C, 32'h1234_5678, 4'b1111, "R6");
    doAccess(0, C, 0, 0, "R7");
    doAccess(1, D, 32'hAB00_0000, 4'b1000, "R10");
    doAccess(0, D, 0, 0, "R10");
    doAccess(1, D, 32'h0000_00CD, 4'b0001, "R5");
    doAccess(0, D, 0, 0, "R10");
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ad;
      logic [2:0]  idxPick;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      idxPick = lfsr[2:0];
      ad = {21'd0, lfsr[5:4], idxPick[1:0] == 0 ? 4'd0 : (idxPick[1:0] == 1 ? 4'd3 :
            (idxPick[1:0] == 2 ? 4'd8 : 4'd15)), lfsr[8:6], 2'b00};
      if (lfsr[9]) doAccess(1, ad, lfsr ^ 32'h3C3C_A5A5, lfsr[13:10] | 4'b0001, "R1");
      else         doAccess(0, ad, 0, 0, "R1");
    end
    finalFlushCheck();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCnt);
      summary();
    end
  end

endmodule